// File: doc/BRIEF.md
# YUYV to RGB24 Pixel Converter

This block turns a packed 4:2:2 video stream into RGB888 pixels. Each 16-bit input word holds one luma byte and one chroma byte. Two consecutive words of a line form a macropixel: the first (even) word carries Y0 with U, and the second (odd) word carries Y1 with V. Each macropixel becomes two RGB pixels that share its U and V. Chroma is subsampled only horizontally, so every line brings its own chroma. A static input, `luma_hi`, says which byte lane of the word holds luma.

Input and output both use a valid/ready handshake. Line-start and line-end markers travel with the pixels. The colour transform is fixed-point limited-range BT.601, followed by a clamp to 0..255. The pipeline sustains one pixel per clock. A stalled output freezes every stage at once. A line that ends on an even word leaves half a macropixel. That word is dropped and a sticky error flag is raised.

Two small state machines control the block. The phase machine has two states. PH_EVEN expects a Y0/U word and moves to PH_ODD on accepting one. PH_ODD expects a Y1/V word and returns to PH_EVEN on accepting one. A line-start word is always handled as PH_EVEN, whatever the current state. A PH_EVEN word that also carries line-end keeps the machine in PH_EVEN and sets the error. The issue machine also has two states. ISS_IDLE passes the Y0 pixel to the pipeline in the same cycle the odd word is accepted, then moves to ISS_SECOND. ISS_SECOND issues the Y1 pixel on the next advancing cycle and returns to ISS_IDLE.

Top module: `yuyv_rgb_conv`

## Requirements
- R1: After reset, out_valid and err_flag are 0 and in_ready is 1.
- R2: With luma_hi=0, luma is in_data[7:0] and chroma is in_data[15:8]. With luma_hi=1 the two lanes are swapped. Byte-swapped input under luma_hi=1 gives the same pixels as the original input under luma_hi=0. luma_hi only changes while no words are in flight.
- R3: Within a line, even words carry U and odd words carry V. Each completed macropixel gives exactly two output pixels, both using its U and V, with the Y0 pixel before the Y1 pixel.
- R4: Each channel is computed with Yd=Y-16, Ud=U-128 and Vd=V-128. R=(298Yd+409Vd+128)>>>8, G=(298Yd-100Ud-208Vd+128)>>>8 and B=(298Yd+516Ud+128)>>>8, where >>> is an arithmetic (floor) shift.
- R5: Each channel is clamped to 0..255. out_rgb packs R in [23:16], G in [15:8] and B in [7:0].
- R6: With out_ready held high and the pipeline empty, the Y0 pixel is presented two clock edges after the edge that accepts the odd word. That makes three register stages, counting the accepting edge.
- R7: While out_valid is 1 and out_ready is 0, out_rgb and the markers hold and in_ready is 0. No pixel is lost or repeated.
- R8: A word with in_sol=1 is always treated as an even (Y0/U) word. Any half-gathered macropixel is discarded without an error.
- R9: A word with in_eol=1 that is treated as even, including one with in_sol=1 as well, produces no pixel and sets err_flag. err_flag then stays 1 until reset.
- R10: out_sol is 1 on the Y0 pixel of a macropixel whose even word had in_sol. out_eol is 1 on the Y1 pixel of a macropixel whose odd word had in_eol. Both are 0 on every other pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_hi | input | 1 | Selects the high byte lane as luma |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | 16 | Packed luma and chroma bytes |
| in_sol | input | 1 | Word is the first of a line |
| in_eol | input | 1 | Word is the last of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_rgb | output | 24 | R, G, B bytes |
| out_sol | output | 1 | Pixel starts a line |
| out_eol | output | 1 | Pixel ends a line |
| err_flag | output | 1 | Sticky flag for a line that ended on an even word |

## Verification
The bench goes after the chroma pairing. A design that took the V of the next macropixel, or the U of the following one, would give wrong colours on the Y1 pixel. It also drives extreme luma and chroma values. A missing clamp would wrap these to small or large bytes, and a wrong rounding shift would be off by one. Random output stalls under a continuous input stream show whether a pixel is dropped or repeated at the hand-off from ISS_IDLE to ISS_SECOND. Three further cases cover the line markers: a stray half macropixel before a line start must vanish silently, a lone line-end word must give no pixel and a lasting error, and a lane-swapped stream must give identical pixels.

// File: rtl/yuyv_pkg.sv
package yuyv_pkg;

    localparam int CW    = 8;
    localparam int SW    = 20;
    localparam int FRAC  = 8;
    localparam int DW    = 2 * CW;
    localparam int NCH   = 3;

    localparam int K_Y   = 298;
    localparam int K_RV  = 409;
    localparam int K_GU  = 100;
    localparam int K_GV  = 208;
    localparam int K_BU  = 516;
    localparam int RND   = 1 << (FRAC - 1);
    localparam int Y_OFS = 16;
    localparam int C_OFS = 128;

    typedef struct packed {
        logic [CW-1:0] y;
        logic [CW-1:0] u;
        logic [CW-1:0] v;
        logic          sol;
        logic          eol;
    } pix_t;

    typedef enum logic { PH_EVEN, PH_ODD } ph_t;
    typedef enum logic { ISS_IDLE, ISS_SECOND } iss_t;

endpackage

// File: rtl/yuyv_pair_issue.sv
module yuyv_pair_issue
    import yuyv_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          luma_hi,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_sol,
    input  logic          in_eol,
    output logic          iss_valid,
    output pix_t          iss_pix,
    output logic          err_flag
);

    ph_t           ph_q, ph_d;
    iss_t          st_q, st_d;
    logic [CW-1:0] y0_q, y0_d, y1_q, y1_d, u_q, u_d, v_q, v_d;
    logic          sol_q, sol_d, eol_q, eol_d, err_q, err_d;

    logic [CW-1:0] y_b, c_b;
    logic          acc, even_word;

    assign y_b       = luma_hi ? in_data[DW-1:CW] : in_data[CW-1:0];
    assign c_b       = luma_hi ? in_data[CW-1:0]  : in_data[DW-1:CW];
    assign acc       = in_valid && adv;
    assign even_word = in_sol || (ph_q == PH_EVEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_EVEN;
            st_q  <= ISS_IDLE;
            y0_q  <= '0;
            y1_q  <= '0;
            u_q   <= '0;
            v_q   <= '0;
            sol_q <= 1'b0;
            eol_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            st_q  <= st_d;
            y0_q  <= y0_d;
            y1_q  <= y1_d;
            u_q   <= u_d;
            v_q   <= v_d;
            sol_q <= sol_d;
            eol_q <= eol_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        st_d  = st_q;
        y0_d  = y0_q;
        y1_d  = y1_q;
        u_d   = u_q;
        v_d   = v_q;
        sol_d = sol_q;
        eol_d = eol_q;
        err_d = err_q;
        if (adv) begin
            st_d = ISS_IDLE;
            if (acc) begin
                if (even_word) begin
                    if (in_eol) begin
                        ph_d  = PH_EVEN;
                        err_d = 1'b1;
                    end else begin
                        ph_d  = PH_ODD;
                        y0_d  = y_b;
                        u_d   = c_b;
                        sol_d = in_sol;
                    end
                end else begin
                    ph_d  = PH_EVEN;
                    y1_d  = y_b;
                    v_d   = c_b;
                    eol_d = in_eol;
                    st_d  = ISS_SECOND;
                end
            end
        end
    end

    always_comb begin
        iss_valid = 1'b0;
        iss_pix   = '0;
        unique case (st_q)
            ISS_SECOND: begin
                iss_valid   = 1'b1;
                iss_pix.y   = y1_q;
                iss_pix.u   = u_q;
                iss_pix.v   = v_q;
                iss_pix.sol = 1'b0;
                iss_pix.eol = eol_q;
            end
            ISS_IDLE: begin
                if (acc && !even_word) begin
                    iss_valid   = 1'b1;
                    iss_pix.y   = y0_q;
                    iss_pix.u   = u_q;
                    iss_pix.v   = c_b;
                    iss_pix.sol = sol_q;
                    iss_pix.eol = 1'b0;
                end
            end
            default: ;
        endcase
    end

    assign err_flag = err_q;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R9
    eol_even_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_eol && even_word) |=> err_flag);

    // R3
    pend_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ISS_SECOND) |-> (ph_q == PH_EVEN));

endmodule

// File: rtl/yuyv_csc_core.sv
module yuyv_csc_core
    import yuyv_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   iss_valid,
    input  pix_t                   iss_pix,
    output logic                   sum_valid,
    output logic [NCH-1:0][SW-1:0] sum_ch,
    output logic                   sum_sol,
    output logic                   sum_eol
);

    localparam int DFW = CW + 2;
    localparam logic signed [DFW-1:0] OFS_Y = DFW'(Y_OFS);
    localparam logic signed [DFW-1:0] OFS_C = DFW'(C_OFS);
    localparam logic signed [SW-1:0]  CY    = SW'(K_Y);
    localparam logic signed [SW-1:0]  CRV   = SW'(K_RV);
    localparam logic signed [SW-1:0]  CGU   = SW'(K_GU);
    localparam logic signed [SW-1:0]  CGV   = SW'(K_GV);
    localparam logic signed [SW-1:0]  CBU   = SW'(K_BU);
    localparam logic signed [SW-1:0]  CRND  = SW'(RND);

    logic signed [DFW-1:0] yd_c, ud_c, vd_c;
    logic                  s1_v, s1_sol, s1_eol;
    logic signed [DFW-1:0] s1_yd, s1_ud, s1_vd;
    logic signed [SW-1:0]  ey, eu, ev, r_c, g_c, b_c;

    assign yd_c = $signed({2'b00, iss_pix.y}) - OFS_Y;
    assign ud_c = $signed({2'b00, iss_pix.u}) - OFS_C;
    assign vd_c = $signed({2'b00, iss_pix.v}) - OFS_C;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_sol <= 1'b0;
            s1_eol <= 1'b0;
            s1_yd  <= '0;
            s1_ud  <= '0;
            s1_vd  <= '0;
        end else if (adv) begin
            s1_v   <= iss_valid;
            s1_sol <= iss_pix.sol;
            s1_eol <= iss_pix.eol;
            s1_yd  <= yd_c;
            s1_ud  <= ud_c;
            s1_vd  <= vd_c;
        end
    end

    assign ey  = SW'(s1_yd);
    assign eu  = SW'(s1_ud);
    assign ev  = SW'(s1_vd);
    assign r_c = CY * ey + CRV * ev + CRND;
    assign g_c = CY * ey - CGU * eu - CGV * ev + CRND;
    assign b_c = CY * ey + CBU * eu + CRND;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_valid <= 1'b0;
            sum_sol   <= 1'b0;
            sum_eol   <= 1'b0;
            sum_ch    <= '0;
        end else if (adv) begin
            sum_valid <= s1_v;
            sum_sol   <= s1_sol;
            sum_eol   <= s1_eol;
            sum_ch[0] <= r_c;
            sum_ch[1] <= g_c;
            sum_ch[2] <= b_c;
        end
    end

endmodule

// File: rtl/yuyv_sat_out.sv
module yuyv_sat_out
    import yuyv_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   sum_valid,
    input  logic [NCH-1:0][SW-1:0] sum_ch,
    input  logic                   sum_sol,
    input  logic                   sum_eol,
    output logic                   out_valid,
    output logic [NCH*CW-1:0]      out_rgb,
    output logic                   out_sol,
    output logic                   out_eol
);

    localparam logic signed [SW-1:0] MAXV = SW'((1 << CW) - 1);

    logic [NCH-1:0][CW-1:0] ch_c;
    logic [NCH*CW-1:0]      rgb_c;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic signed [SW-1:0] sh;
        assign sh      = $signed(sum_ch[k]) >>> FRAC;
        assign ch_c[k] = (sh < 0) ? '0 : ((sh > MAXV) ? '1 : sh[CW-1:0]);
        assign rgb_c[(NCH-1-k)*CW +: CW] = ch_c[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (adv) begin
            out_valid <= sum_valid;
            out_rgb   <= rgb_c;
            out_sol   <= sum_sol;
            out_eol   <= sum_eol;
        end
    end

endmodule

// File: rtl/yuyv_rgb_conv.sv
module yuyv_rgb_conv
    import yuyv_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          luma_hi,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [15:0]   in_data,
    input  logic          in_sol,
    input  logic          in_eol,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [23:0]   out_rgb,
    output logic          out_sol,
    output logic          out_eol,
    output logic          err_flag
);

    logic                   adv;
    logic                   iss_valid;
    pix_t                   iss_pix;
    logic                   sum_valid, sum_sol, sum_eol;
    logic [NCH-1:0][SW-1:0] sum_ch;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    yuyv_pair_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .luma_hi   (luma_hi),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .iss_valid (iss_valid),
        .iss_pix   (iss_pix),
        .err_flag  (err_flag)
    );

    yuyv_csc_core u_csc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .iss_valid (iss_valid),
        .iss_pix   (iss_pix),
        .sum_valid (sum_valid),
        .sum_ch    (sum_ch),
        .sum_sol   (sum_sol),
        .sum_eol   (sum_eol)
    );

    yuyv_sat_out u_sat (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .sum_valid (sum_valid),
        .sum_ch    (sum_ch),
        .sum_sol   (sum_sol),
        .sum_eol   (sum_eol),
        .out_valid (out_valid),
        .out_rgb   (out_rgb),
        .out_sol   (out_sol),
        .out_eol   (out_eol)
    );

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_eol)));

    // R10
    sol_not_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sol) |-> !out_eol);

endmodule

// File: tb/sim_yuyv_rgb_conv.sv
module sim_yuyv_rgb_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        luma_hi = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_rgb;
    logic        out_sol, out_eol, err_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int lat_cyc = -1;
    bit lat_arm = 1'b0;
    bit bp_en = 1'b0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    bit          prev_stall = 1'b0;
    logic [25:0] prev_out;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    yuyv_rgb_conv u0 (
        .clk(clk), .rst_n(rst_n), .luma_hi(luma_hi),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
        .out_sol(out_sol), .out_eol(out_eol), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int clamp8(input int x);
        if (x < 0) return 0;
        if (x > 255) return 255;
        return x;
    endfunction

    function automatic logic [23:0] model(input int y, input int u, input int v);
        int yd, ud, vd, r, g, b;
        yd = y - 16;
        ud = u - 128;
        vd = v - 128;
        r = (298 * yd + 409 * vd + 128) >>> 8;
        g = (298 * yd - 100 * ud - 208 * vd + 128) >>> 8;
        b = (298 * yd + 516 * ud + 128) >>> 8;
        return {8'(clamp8(r)), 8'(clamp8(g)), 8'(clamp8(b))};
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && ({out_rgb, out_sol, out_eol} == prev_out),
                    "R7 hold", {6'd0, out_rgb, out_sol, out_eol}, {6'd0, prev_out});
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_rgb, out_sol, out_eol};
            if (lat_arm && out_valid) begin
                lat_cyc = cyc;
                lat_arm = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected pixel", {6'd0, out_rgb, out_sol, out_eol}, 32'd0);
                end else begin
                    logic [25:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_rgb, out_sol, out_eol} == e, t,
                        {6'd0, out_rgb, out_sol, out_eol}, {6'd0, e});
                end
            end
        end
    end

    // random backpressure
    always @(posedge clk) begin
        #1;
        if (bp_en) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[2];
        end
    end

    task automatic send_word(input int y, input int c, input bit sol, input bit eol);
        bit got;
        in_valid = 1'b1;
        in_data  = luma_hi ? {8'(y), 8'(c)} : {8'(c), 8'(y)};
        in_sol   = sol;
        in_eol   = eol;
        do begin
            @(negedge clk);
            got = in_ready;
            @(posedge clk);
            #1;
        end while (!got);
        acc_cyc  = cyc;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic send_pair(input int y0, input int y1, input int u, input int v,
                             input bit sol, input bit eol, input string tag);
        exp_q.push_back({model(y0, u, v), sol, 1'b0});
        tag_q.push_back({tag, " Y0"});
        exp_q.push_back({model(y1, u, v), 1'b0, eol});
        tag_q.push_back({tag, " Y1"});
        send_word(y0, u, sol, 1'b0);
        send_word(y1, v, 1'b0, eol);
    endtask

    task automatic drain();
        repeat (12) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R1 reset state (held in reset)
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(err_flag == 1'b0, "R1 err_flag", 32'(err_flag), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1;

        // R6 latency on an empty pipeline
        exp_q.push_back({model(120, 90, 200), 1'b1, 1'b0});
        tag_q.push_back("R6 latency Y0");
        exp_q.push_back({model(60, 90, 200), 1'b0, 1'b1});
        tag_q.push_back("R6 latency Y1");
        send_word(120, 90, 1'b1, 1'b0);
        lat_arm = 1'b1;
        send_word(60, 200, 1'b0, 1'b1);
        drain();
        chk(lat_cyc - acc_cyc == 2, "R6 latency", 32'(lat_cyc - acc_cyc), 32'd2);

        // R3 R4 R10 a line of several macropixels
        send_pair(16, 235, 128, 128, 1'b1, 1'b0, "R3 R4 R10 grey");
        send_pair(81, 82, 90, 240, 1'b0, 1'b0, "R3 R4 red");
        send_pair(145, 144, 54, 34, 1'b0, 1'b0, "R3 R4 green");
        send_pair(41, 40, 240, 110, 1'b0, 1'b1, "R3 R4 R10 blue eol");
        drain();

        // R5 clamp corners
        send_pair(255, 0, 255, 255, 1'b1, 1'b0, "R5 clamp hi");
        send_pair(0, 255, 0, 0, 1'b0, 1'b1, "R5 clamp lo");
        drain();

        // R2 swapped lane gives the same pixels
        luma_hi = 1'b1;
        send_pair(81, 82, 90, 240, 1'b1, 1'b0, "R2 swapped");
        send_pair(200, 17, 30, 220, 1'b0, 1'b1, "R2 swapped");
        drain();
        luma_hi = 1'b0;

        // R7 random backpressure over a long line
        bp_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            send_pair((i * 37 + 5) % 256, (i * 91 + 200) % 256, (i * 53 + 11) % 256,
                      (i * 29 + 140) % 256, i == 0, i == 23, "R7 stream");
        end
        repeat (80) @(posedge clk);
        bp_en = 1'b0;
        #1;
        out_ready = 1'b1;
        drain();
        chk(exp_q.size() == 0, "R7 no loss", 32'(exp_q.size()), 32'd0);

        // R8 stray half macropixel then a line start
        send_word(99, 77, 1'b1, 1'b0);
        send_pair(70, 180, 100, 160, 1'b1, 1'b1, "R8 resync");
        drain();
        chk(err_flag == 1'b0, "R8 no error", 32'(err_flag), 32'd0);

        // R9 line end on an even word
        send_word(50, 60, 1'b1, 1'b1);
        drain();
        chk(err_flag == 1'b1, "R9 error set", 32'(err_flag), 32'd1);
        chk(exp_q.size() == 0, "R9 no pixel", 32'(exp_q.size()), 32'd0);
        send_word(10, 20, 1'b0, 1'b1);
        drain();
        chk(exp_q.size() == 0, "R9 odd-looking word after drop gives no pixel",
            32'(exp_q.size()), 32'd0);
        send_pair(130, 131, 128, 128, 1'b1, 1'b1, "R9 after error");
        drain();
        chk(err_flag == 1'b1, "R9 sticky", 32'(err_flag), 32'd1);
        chk(exp_q.size() == 0, "R3 queue empty", 32'(exp_q.size()), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule